// File: doc/BRIEF.md
# Serial Mode and Synthesizer Control Register

This block is the write-only control port of a dual-mode radio baseband interface. A host shifts 24-bit words in on a three-wire link made of a serial clock, a data line and a latch strobe. When the latch rises, the word is decoded. Its two lowest bits select one of two internal register words. The divider word holds the 14-bit receive synthesizer divide ratio and the reference-rate select bit. The control word holds the mode override and serial mode bits, the test bit, the auxiliary mux override and select bits, and the calibration control bit.

The block also merges the external active-low mode pins with the serial mode bits to give a one-hot operating mode. It merges the external mux select pins with the serial mux bits to give the auxiliary converter channel. When the mode moves into either CDMA state, it raises a single-cycle pulse that can start receive filter calibration.

All inputs are sampled on the system clock `clk`. The serial clock and latch are detected by their rising edges in that domain, so each must stay high and low for at least one `clk` cycle.

Top module: `serial_ctl_reg`

## Requirements
- R1: After reset the divider is 0, the rate bit is 0, the test and calibration-control outputs are 0, the mode follows the pins and the mux select follows the pins.
- R2: Bits are captured MSB first, one per rising edge of `ser_clk`. On a rising edge of `ser_latch`, a complete word with bits [1:0] = 01 loads the divider from bits [15:2] and the rate bit from bit 16 (0 = 30 kHz, 1 = 5 kHz).
- R3: On the latch, a complete word with bits [1:0] = 10 loads the control fields: bit 2 override, bit 3 serial FM_n, bit 4 serial idle_n, bit 5 serial sleep_n, bit 6 test, bit 7 mux select bit 0, bit 8 mux select bit 1, bit 9 mux override, bit 10 calibration control.
- R4: A complete word with bits [1:0] = 00 or 11 changes no stored field.
- R5: Serial clock edges after the 24th bit and before the latch are ignored, so the first 24 bits form the word. A latch after fewer than 24 bits discards them. In both cases a latch starts a new word.
- R6: With the override bit 0 the mode controls come from the pins. With it 1 they come from the serial sleep_n, FM_n and idle_n bits.
- R7: The mode is one-hot as follows. Bit 0 is sleep, selected when sleep_n is 0, whatever the other controls are. Bit 1 is FM receive (FM_n=0, idle_n=0). Bit 2 is FM receive and transmit (FM_n=0, idle_n=1). Bit 3 is CDMA receive (FM_n=1, idle_n=0). Bit 4 is CDMA receive and transmit (FM_n=1, idle_n=1).
- R8: `cal_pulse` is high for exactly one cycle, in the cycle after the mode first shows a CDMA state (bit 3 or 4) that it did not show in the previous cycle. The cycle before reset release counts as non-CDMA. A move between the two CDMA states gives no pulse.
- R9: With the mux override bit 0, `aux_sel` follows the pins. With it 1, it follows the serial mux select bits.
- R10: The `test_en` and `cal_ctl` outputs show the stored test and calibration-control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, rising edge captures a bit |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Rising edge commits the shifted word |
| pin_sleep_n | input | 1 | External sleep control, active low |
| pin_fm_n | input | 1 | External FM select, active low |
| pin_idle_n | input | 1 | External idle control, active low |
| pin_aux_sel | input | 2 | External auxiliary channel select |
| rx_div | output | 14 | Receive synthesizer divide ratio |
| ref_slow | output | 1 | Reference rate select, 1 = 5 kHz |
| mode_oh | output | 5 | One-hot operating mode |
| cal_pulse | output | 1 | One-cycle calibration start |
| aux_sel | output | 2 | Effective auxiliary channel select |
| test_en | output | 1 | Stored test bit |
| cal_ctl | output | 1 | Stored calibration control bit |

## Verification
If the bit counter or shift register goes wrong, the wrong value shows up on `rx_div` or on the control outputs one cycle after the latch rises. A word that should have been dropped instead changes an output. If the override or decode logic goes wrong, `mode_oh` or `aux_sel` mismatches in the same cycle as the pin or register change. A wrong edge history for the CDMA state gives a missing, repeated or misplaced `cal_pulse` one cycle after the mode change. The bench model is compared against every output on every clock, so each such error is caught in the first cycle it appears.

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_latch,
  input  logic             pin_sleep_n,
  input  logic             pin_fm_n,
  input  logic             pin_idle_n,
  input  logic [1:0]       pin_aux_sel,
  output logic [DIV_W-1:0] rx_div,
  output logic             ref_slow,
  output logic [4:0]       mode_oh,
  output logic             cal_pulse,
  output logic [1:0]       aux_sel,
  output logic             test_en,
  output logic             cal_ctl
);
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int DIV_LSB  = 2;
  localparam int RATE_BIT = DIV_LSB + DIV_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;
  logic              sclk_q, latch_q;
  logic              sop, s_fm_n, s_idle_n, s_sleep_n, mxs;
  logic [1:0]        s_aux;
  logic              was_cdma;

  wire sclk_rise  = ser_clk & ~sclk_q;
  wire latch_rise = ser_latch & ~latch_q;
  wire commit     = latch_rise && (nbits == FULL);
  wire is_div     = commit && (shreg[1:0] == 2'b01);
  wire is_ctl     = commit && (shreg[1:0] == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      shreg   <= '0;
      nbits   <= '0;
    end else begin
      sclk_q  <= ser_clk;
      latch_q <= ser_latch;
      if (latch_rise) begin
        nbits <= '0;
      end else if (sclk_rise && nbits != FULL) begin
        shreg <= {shreg[WORD_W-2:0], ser_data};
        nbits <= nbits + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_div   <= '0;
      ref_slow <= 1'b0;
    end else if (is_div) begin
      rx_div   <= shreg[RATE_BIT-1:DIV_LSB];
      ref_slow <= shreg[RATE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cal_ctl, mxs, s_aux, test_en, s_sleep_n, s_idle_n, s_fm_n, sop} <= '0;
    end else if (is_ctl) begin
      {cal_ctl, mxs, s_aux, test_en, s_sleep_n, s_idle_n, s_fm_n, sop} <= shreg[10:2];
    end
  end

  wire eff_sleep_n = sop ? s_sleep_n : pin_sleep_n;
  wire eff_fm_n    = sop ? s_fm_n    : pin_fm_n;
  wire eff_idle_n  = sop ? s_idle_n  : pin_idle_n;

  assign mode_oh = !eff_sleep_n ? 5'b00001 :
                   {eff_fm_n & eff_idle_n, eff_fm_n & ~eff_idle_n,
                    ~eff_fm_n & eff_idle_n, ~eff_fm_n & ~eff_idle_n, 1'b0};
  assign aux_sel = mxs ? s_aux : pin_aux_sel;

  wire in_cdma = mode_oh[3] | mode_oh[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_cdma  <= 1'b0;
      cal_pulse <= 1'b0;
    end else begin
      was_cdma  <= in_cdma;
      cal_pulse <= in_cdma & ~was_cdma;
    end
  end

  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n) nbits <= FULL);

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_rise |=> $stable(rx_div) && $stable(ref_slow));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |=> !cal_pulse);

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> $past(in_cdma));

  // R7
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode_oh) && mode_oh != 5'b0);
endmodule

// File: tb/serial_ctl_reg_test.sv
module serial_ctl_reg_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_latch = 0;
  logic pin_sleep_n = 0, pin_fm_n = 0, pin_idle_n = 0;
  logic [1:0] pin_aux_sel = 0;
  logic [13:0] rx_div;
  logic ref_slow, cal_pulse, test_en, cal_ctl;
  logic [4:0] mode_oh;
  logic [1:0] aux_sel;

  int checks = 0, errors = 0;
  int pulses = 0;

  serial_ctl_reg uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit [23:0] m_sr;
  int m_cnt;
  bit m_sp, m_lp;
  int m_div, m_rate;
  bit m_sop, m_sfm, m_sid, m_ssl, m_tst, m_mxs, m_ctb;
  bit [1:0] m_aux;
  bit m_was, m_pulse;

  function automatic bit [4:0] ref_mode();
    bit sl, fm, id;
    sl = m_sop ? m_ssl : pin_sleep_n;
    fm = m_sop ? m_sfm : pin_fm_n;
    id = m_sop ? m_sid : pin_idle_n;
    if (!sl) return 5'b00001;
    case ({fm, id})
      2'b00: return 5'b00010;
      2'b01: return 5'b00100;
      2'b10: return 5'b01000;
      default: return 5'b10000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sr = 0; m_cnt = 0; m_sp = 0; m_lp = 0; m_div = 0; m_rate = 0;
      {m_sop, m_sfm, m_sid, m_ssl, m_tst, m_mxs, m_ctb} = 0; m_aux = 0;
      m_was = 0; m_pulse = 0;
    end else begin
      bit [4:0] md;
      md = ref_mode();
      m_pulse = (md[3] || md[4]) && !m_was;
      m_was = md[3] || md[4];
      if (ser_latch && !m_lp) begin
        if (m_cnt == 24) begin
          if (m_sr[1:0] == 2'b01) begin
            m_div = m_sr[15:2]; m_rate = m_sr[16];
          end else if (m_sr[1:0] == 2'b10) begin
            m_sop = m_sr[2]; m_sfm = m_sr[3]; m_sid = m_sr[4]; m_ssl = m_sr[5];
            m_tst = m_sr[6]; m_aux = {m_sr[8], m_sr[7]}; m_mxs = m_sr[9]; m_ctb = m_sr[10];
          end
        end
        m_cnt = 0;
      end else if (ser_clk && !m_sp && m_cnt < 24) begin
        m_sr = {m_sr[22:0], ser_data};
        m_cnt++;
      end
      m_sp = ser_clk; m_lp = ser_latch;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(rx_div == m_div[13:0], "R2 rx_div", rx_div, m_div);
    check(ref_slow == m_rate[0], "R2 ref_slow", ref_slow, m_rate);
    check(mode_oh == ref_mode(), "R7 mode", mode_oh, ref_mode());
    check(cal_pulse == m_pulse, "R8 cal_pulse", cal_pulse, m_pulse);
    check(aux_sel == (m_mxs ? m_aux : pin_aux_sel), "R9 aux_sel", aux_sel, m_mxs ? m_aux : pin_aux_sel);
    check(test_en == m_tst && cal_ctl == m_ctb, "R10 test/cal", {test_en, cal_ctl}, {m_tst, m_ctb});
    if (cal_pulse) pulses++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic shift(input bit [31:0] w, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      ser_data = w[i];
      ser_clk = 0; tick(2);
      ser_clk = 1; tick(2);
    end
    ser_clk = 0; tick(1);
  endtask

  task automatic latch();
    ser_latch = 1; tick(2);
    ser_latch = 0; tick(2);
  endtask

  function automatic bit [23:0] div_word(input bit [13:0] d, input bit r);
    return {7'b0, r, d, 2'b01};
  endfunction

  function automatic bit [23:0] ctl_word(input bit ctb, mxs, ad1, ad0, tst, slb, idb, fmb, sop);
    return {13'b0, ctb, mxs, ad1, ad0, tst, slb, idb, fmb, sop, 2'b10};
  endfunction

  task automatic set_pins(input bit sl, fm, id);
    pin_sleep_n = sl; pin_fm_n = fm; pin_idle_n = id; tick(3);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    pin_aux_sel = 2'b10;
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check(rx_div == 0 && ref_slow == 0, "R1 divider reset", {ref_slow, rx_div}, 0);
    check(test_en == 0 && cal_ctl == 0, "R1 control reset", {test_en, cal_ctl}, 0);
    check(mode_oh == 5'b00001 && aux_sel == 2'b10, "R1 pin control", {mode_oh, aux_sel}, 7'b0000110);

    // R7 pin decode, sleep dominates
    set_pins(0, 1, 1);
    check(mode_oh == 5'b00001, "R7 sleep", mode_oh, 1);
    set_pins(1, 0, 0);
    check(mode_oh == 5'b00010, "R7 fm rx", mode_oh, 2);
    set_pins(1, 0, 1);
    check(mode_oh == 5'b00100, "R7 fm rxtx", mode_oh, 4);
    p0 = pulses;
    set_pins(1, 1, 0);
    check(mode_oh == 5'b01000, "R7 cdma rx", mode_oh, 8);
    check(pulses == p0 + 1, "R8 pulse on cdma entry", pulses - p0, 1);
    p0 = pulses;
    set_pins(1, 1, 1);
    check(mode_oh == 5'b10000 && pulses == p0, "R8 no pulse cdma to cdma", pulses - p0, 0);

    // R2 divider word
    shift(div_word(14'h2A5B, 1), 24); latch();
    check(rx_div == 14'h2A5B && ref_slow == 1, "R2 divider load", rx_div, 14'h2A5B);
    shift(div_word(14'h0137, 0), 24); latch();
    check(rx_div == 14'h0137 && ref_slow == 0, "R2 divider reload", rx_div, 14'h0137);

    // R4 discarded addresses
    shift({div_word(14'h3FFF, 1)} & 24'hFFFFFC, 24); latch();
    check(rx_div == 14'h0137, "R4 addr 00 ignored", rx_div, 14'h0137);
    shift(div_word(14'h1111, 1) | 24'h3, 24); latch();
    check(rx_div == 14'h0137 && test_en == 0, "R4 addr 11 ignored", rx_div, 14'h0137);

    // R5 extra bits ignored, partial word discarded
    shift({div_word(14'h0F0F, 1), 6'b111111}, 30); latch();
    check(rx_div == 14'h0F0F && ref_slow == 1, "R5 extra bits ignored", rx_div, 14'h0F0F);
    shift(div_word(14'h0001, 0), 10); latch();
    check(rx_div == 14'h0F0F, "R5 partial word discarded", rx_div, 14'h0F0F);
    shift(div_word(14'h0ABC, 0), 24); latch();
    check(rx_div == 14'h0ABC, "R5 fresh word after partial", rx_div, 14'h0ABC);

    // R3 R6 R9 R10 control word with override
    set_pins(1, 0, 0);
    p0 = pulses;
    shift(ctl_word(1, 1, 0, 1, 1, 1, 1, 1, 1), 24); latch();
    check(mode_oh == 5'b10000, "R6 serial override", mode_oh, 16);
    check(pulses == p0 + 1, "R8 pulse via serial", pulses - p0, 1);
    check(aux_sel == 2'b01, "R9 serial mux", aux_sel, 1);
    check(test_en == 1 && cal_ctl == 1, "R10 stored bits", {test_en, cal_ctl}, 3);
    set_pins(0, 0, 0);
    check(mode_oh == 5'b10000, "R6 pins ignored under override", mode_oh, 16);
    shift(ctl_word(0, 0, 1, 1, 0, 1, 0, 0, 1), 24); latch();
    check(mode_oh == 5'b00010 && aux_sel == pin_aux_sel, "R3 fields reload", {mode_oh, aux_sel}, {5'b00010, pin_aux_sel});
    shift(ctl_word(0, 0, 0, 0, 0, 0, 1, 1, 1), 24); latch();
    check(mode_oh == 5'b00001, "R7 serial sleep", mode_oh, 1);
    shift(ctl_word(0, 0, 0, 0, 0, 1, 1, 1, 0), 24); latch();
    set_pins(1, 0, 1);
    check(mode_oh == 5'b00100 && test_en == 0, "R6 back to pins", mode_oh, 4);

    tick(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule